// File: doc/BRIEF.md
# Serial-Access Real-Time Clock Register Slave

This block is the always-powered half of a real-time clock. It keeps a 32-bit seconds counter, a 32-bit second-adjust word that is plain storage, and four 32-bit scratch words that hold state across a suspend. A host reaches all of them through a slow bit-banged serial port. The port has an enable line, a serial clock and a data-in line toward the block, and a data-out line and a ready flag back to the host. The seconds counter advances on a one-cycle tick input that a divider elsewhere generates once per second.

The serial lines are asynchronous to the block's clock. They are resynchronised, and the block acts on rising edges of the serial clock that it detects in its own clock domain. A write frame carries the data word first and the address after it. A read frame carries only the address. In both cases the transfer direction comes from a separate bit that the host clocks in after enable drops. Frames whose bit count or direction bit does not match are dropped, and no register changes.

Top module: `rtc_serial_slave`

## Requirements
- R1: Address 0 is the seconds counter, address 2 is the second-adjust word, and addresses 4, 5, 6 and 7 are scratch words. Each is 32 bits wide and reads back the last value written to it.
- R2: A write frame sends, while ser_en is high, 32 data bits MSB first and then 3 address bits MSB first, each sampled on a rising edge of ser_clk. After ser_en falls, one more ser_clk rising edge with ser_din = 1 commits the word to the addressed register.
- R3: A read frame sends 3 address bits MSB first while ser_en is high. After ser_en falls, a ser_clk rising edge with ser_din = 0 follows. On each of the next 32 ser_clk rising edges the block then puts the next data bit on ser_dout, MSB first, and the bit stays there until the following rising edge.
- R4: On every cycle where sec_tick is high, the counter increments by one, and it wraps from 0xFFFFFFFF to 0.
- R5: A committed write to address 0 loads the counter. If the write and a tick fall in the same cycle, the written value wins.
- R6: A write to address 1 or 3 changes no register, and a read of address 1 or 3 returns zero.
- R7: A frame in which ser_en falls after a bit count other than 35 (write) or 3 (read) is cancelled. The direction bit that follows has no effect.
- R8: A 35-bit frame followed by a direction bit of 0 writes nothing. A 3-bit frame followed by a direction bit of 1 produces no read-out, and ser_dout stays 0.
- R9: ser_ready is high while the block is idle. It goes low when ser_en rises and returns high once the frame ends: after the write commit, after the 32nd read-out bit, or on cancellation.
- R10: While rst_n is low (asynchronous), the counter, the adjust word and the scratch words read zero, ser_ready is high and ser_dout is 0.
- R11: ser_dout returns to 0 when a new frame begins and otherwise changes only on read-out edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| ser_en | input | 1 | Serial frame enable from host |
| ser_clk | input | 1 | Serial clock from host |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial read data to host |
| ser_ready | output | 1 | High when a new frame may start |

## Verification
The hardest states to reach from the pins are the cancelled frames. Here the host sends a plausible frame that is one bit too long or too short, or ends it with the wrong direction bit, and the block must leave every register untouched and stay silent on ser_dout. The stimulus reaches them by building raw frames bit by bit with arbitrary lengths and direction bits. It then reads the targeted register back through a normal read frame, and checks ser_ready and ser_dout at the pins. A counter loaded to 0xFFFFFFFF and then ticked once covers the wrap.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;

    localparam int RTC_ADDR_W    = 3;
    localparam int RTC_DATA_W    = 32;
    localparam int RTC_SCRATCH_N = 4;

    // register map; scratch words occupy consecutive addresses from the base
    localparam int RTC_COUNT_ADDR   = 0;
    localparam int RTC_ADJ_ADDR     = 2;
    localparam int RTC_SCRATCH_BASE = 4;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_SHIFT,
        FS_WAIT_WR,
        FS_WAIT_RD,
        FS_READOUT
    } frame_state_e;

endpackage

// File: rtl/rtc_ser_sync.sv
module rtc_ser_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.pipe[i] = sync_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.pipe[STAGES-1];

endmodule

// File: rtl/rtc_ser_frame.sv
module rtc_ser_frame
    import rtc_ser_pkg::*;
#(
    parameter int ADDR_W = RTC_ADDR_W,
    parameter int DATA_W = RTC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s_i,
    input  logic              sclk_s_i,
    input  logic              din_s_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              dout_o,
    output logic              ready_o
);

    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int OCNT_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  BITS_WR  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0]  BITS_RD  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0]  BITS_MAX = CNT_W'(FRAME_W + 1);
    localparam logic [OCNT_W-1:0] OCNT_END = OCNT_W'(DATA_W - 1);

    typedef struct packed {
        frame_state_e         state;
        logic [FRAME_W-1:0]   shift;
        logic [CNT_W-1:0]     bits;
        logic [DATA_W-1:0]    outw;
        logic [OCNT_W-1:0]    ocnt;
        logic                 en_prev;
        logic                 sclk_prev;
        logic                 dout;
        logic                 ready;
    } frame_t;

    localparam frame_t FRAME_RST = '{
        state:     FS_IDLE,
        shift:     '0,
        bits:      '0,
        outw:      '0,
        ocnt:      '0,
        en_prev:   1'b0,
        sclk_prev: 1'b0,
        dout:      1'b0,
        ready:     1'b1
    };

    frame_t fr_d, fr_q;
    logic   en_rise, en_fall, sclk_rise;

    assign en_rise   = en_s_i & ~fr_q.en_prev;
    assign en_fall   = ~en_s_i & fr_q.en_prev;
    assign sclk_rise = sclk_s_i & ~fr_q.sclk_prev;

    always_comb begin
        fr_d           = fr_q;
        wr_en_o        = 1'b0;
        fr_d.en_prev   = en_s_i;
        fr_d.sclk_prev = sclk_s_i;
        if (en_rise) begin
            fr_d.state = FS_SHIFT;
            fr_d.bits  = '0;
            fr_d.dout  = 1'b0;
        end else begin
            case (fr_q.state)
                FS_IDLE: ;
                FS_SHIFT: begin
                    if (en_fall) begin
                        if (fr_q.bits == BITS_WR)      fr_d.state = FS_WAIT_WR;
                        else if (fr_q.bits == BITS_RD) fr_d.state = FS_WAIT_RD;
                        else                           fr_d.state = FS_IDLE;
                    end else if (sclk_rise) begin
                        fr_d.shift = {fr_q.shift[FRAME_W-2:0], din_s_i};
                        if (fr_q.bits != BITS_MAX) fr_d.bits = fr_q.bits + 1'b1;
                    end
                end
                FS_WAIT_WR: begin
                    if (sclk_rise) begin
                        wr_en_o    = din_s_i;
                        fr_d.state = FS_IDLE;
                    end
                end
                FS_WAIT_RD: begin
                    if (sclk_rise) begin
                        if (!din_s_i) begin
                            fr_d.outw  = rd_data_i;
                            fr_d.ocnt  = '0;
                            fr_d.state = FS_READOUT;
                        end else begin
                            fr_d.state = FS_IDLE;
                        end
                    end
                end
                FS_READOUT: begin
                    if (sclk_rise) begin
                        fr_d.dout = fr_q.outw[DATA_W-1];
                        fr_d.outw = {fr_q.outw[DATA_W-2:0], 1'b0};
                        fr_d.ocnt = fr_q.ocnt + 1'b1;
                        if (fr_q.ocnt == OCNT_END) fr_d.state = FS_IDLE;
                    end
                end
                default: fr_d.state = FS_IDLE;
            endcase
        end
        fr_d.ready = (fr_d.state == FS_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= FRAME_RST;
        else        fr_q <= fr_d;
    end

    assign rd_addr_o = fr_q.shift[ADDR_W-1:0];
    assign wr_addr_o = fr_q.shift[ADDR_W-1:0];
    assign wr_data_o = fr_q.shift[FRAME_W-1:ADDR_W];
    assign dout_o    = fr_q.dout;
    assign ready_o   = fr_q.ready;

endmodule

// File: rtl/rtc_ser_regs.sv
module rtc_ser_regs
    import rtc_ser_pkg::*;
#(
    parameter int ADDR_W       = RTC_ADDR_W,
    parameter int DATA_W       = RTC_DATA_W,
    parameter int SCRATCH_N    = RTC_SCRATCH_N,
    parameter int COUNT_ADDR   = RTC_COUNT_ADDR,
    parameter int ADJ_ADDR     = RTC_ADJ_ADDR,
    parameter int SCRATCH_BASE = RTC_SCRATCH_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(COUNT_ADDR);
    localparam logic [ADDR_W-1:0] A_ADJ   = ADDR_W'(ADJ_ADDR);

    typedef struct packed {
        logic [DATA_W-1:0]                 count;
        logic [DATA_W-1:0]                 adj;
        logic [SCRATCH_N-1:0][DATA_W-1:0]  scratch;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [SCRATCH_N-1:0] scr_wr_hit;
    logic [SCRATCH_N-1:0] scr_rd_hit;

    for (genvar g = 0; g < SCRATCH_N; g++) begin : g_scr
        assign scr_wr_hit[g] = wr_en_i && (wr_addr_i == ADDR_W'(SCRATCH_BASE + g));
        assign scr_rd_hit[g] = (rd_addr_i == ADDR_W'(SCRATCH_BASE + g));
    end

    always_comb begin
        regs_d = regs_q;
        if (tick_i) regs_d.count = regs_q.count + DATA_W'(1);
        if (wr_en_i && wr_addr_i == A_COUNT) regs_d.count = wr_data_i;
        if (wr_en_i && wr_addr_i == A_ADJ)   regs_d.adj   = wr_data_i;
        for (int i = 0; i < SCRATCH_N; i++) begin
            if (scr_wr_hit[i]) regs_d.scratch[i] = wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == A_COUNT) rd_data_o = regs_q.count;
        if (rd_addr_i == A_ADJ)   rd_data_o = regs_q.adj;
        for (int i = 0; i < SCRATCH_N; i++) begin
            if (scr_rd_hit[i]) rd_data_o = regs_q.scratch[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_ser_pkg::*;
#(
    parameter int ADDR_W      = RTC_ADDR_W,
    parameter int DATA_W      = RTC_DATA_W,
    parameter int SCRATCH_N   = RTC_SCRATCH_N,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic ser_en,
    input  logic ser_clk,
    input  logic ser_din,
    output logic ser_dout,
    output logic ser_ready
);

    logic [2:0]        lines_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    rtc_ser_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en, ser_clk, ser_din}),
        .sync_o  (lines_s)
    );

    rtc_ser_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_s_i    (lines_s[2]),
        .sclk_s_i  (lines_s[1]),
        .din_s_i   (lines_s[0]),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .dout_o    (ser_dout),
        .ready_o   (ser_ready)
    );

    rtc_ser_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SCRATCH_N (SCRATCH_N)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (sec_tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

endmodule

// File: rtl/rtc_ser_checker.sv
module rtc_ser_checker #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] adj,
    input logic              ready,
    input logic              dout
);

    logic load_cnt;
    logic load_adj;
    assign load_cnt = wr_en && (wr_addr == ADDR_W'(0));
    assign load_adj = wr_en && (wr_addr == ADDR_W'(2));

    AST_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_cnt) |=> (count == $past(count) + DATA_W'(1))); // R4

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_cnt) |=> $stable(count)); // R4

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (count == $past(wr_data))); // R5

    AST_ADJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_adj |=> $stable(adj)); // R1

    AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !ready); // R9

    AST_COMMIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ready); // R9

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (!ready || $stable(dout))); // R11

endmodule

bind rtc_serial_slave rtc_ser_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sec_tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count   (u_regs.regs_q.count),
    .adj     (u_regs.regs_q.adj),
    .ready   (ser_ready),
    .dout    (ser_dout)
);

// File: tb/rtc_serial_slave_tb.sv
module rtc_serial_slave_tb;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0;
    logic ser_en = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout;
    logic ser_ready;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rtc_serial_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .ser_en    (ser_en),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .ser_dout  (ser_dout),
        .ser_ready (ser_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        @(negedge clk);
        ser_din = b;
        wait_cyc(H);
        ser_clk = 1'b1;
        wait_cyc(H);
        ser_clk = 1'b0;
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic en_high();
        @(negedge clk);
        ser_en = 1'b1;
        wait_cyc(H);
    endtask

    task automatic en_low();
        @(negedge clk);
        ser_en = 1'b0;
        ser_din = 1'b0;
        wait_cyc(H);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        en_high();
        send_bits({29'd0, d, a}, 35);
        en_low();
        pulse(1'b1);
        wait_cyc(2 * H);
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        d = '0;
        en_high();
        send_bits({61'd0, a}, 3);
        en_low();
        pulse(1'b0);
        for (int i = 0; i < 32; i++) begin
            pulse(1'b0);
            d = {d[30:0], ser_dout};
        end
        wait_cyc(H);
    endtask

    task automatic t_reset();
        chk("R10 ready after reset", {31'd0, ser_ready}, 32'd1);
        chk("R10 dout after reset", {31'd0, ser_dout}, 32'd0);
        begin
            logic [31:0] v;
            reg_read(3'd0, v); chk("R10 counter cleared", v, 32'h0);
            reg_read(3'd5, v); chk("R10 scratch cleared", v, 32'h0);
        end
    endtask

    task automatic t_storage();
        logic [31:0] v;
        reg_write(3'd4, 32'h1357_9BDF);
        reg_write(3'd5, 32'h8000_0001);
        reg_write(3'd6, 32'hFFFF_0000);
        reg_write(3'd7, 32'h0F0F_A5A5);
        reg_write(3'd2, 32'hC001_D00D);
        reg_read(3'd4, v); chk("R1 scratch 4", v, 32'h1357_9BDF);
        reg_read(3'd5, v); chk("R2 R3 MSB-first scratch 5", v, 32'h8000_0001);
        reg_read(3'd6, v); chk("R1 scratch 6", v, 32'hFFFF_0000);
        reg_read(3'd7, v); chk("R1 scratch 7", v, 32'h0F0F_A5A5);
        reg_read(3'd2, v); chk("R1 adjust word", v, 32'hC001_D00D);
    endtask

    task automatic t_counter();
        logic [31:0] v;
        reg_write(3'd0, 32'h1234_0000);
        reg_read(3'd0, v); chk("R5 counter load", v, 32'h1234_0000);
        tick_n(5);
        reg_read(3'd0, v); chk("R4 counter after 5 ticks", v, 32'h1234_0005);
        reg_write(3'd0, 32'hFFFF_FFFF);
        tick_n(1);
        reg_read(3'd0, v); chk("R4 counter wrap", v, 32'h0);
    endtask

    task automatic t_undef();
        logic [31:0] v;
        reg_write(3'd1, 32'hDEAD_BEEF);
        reg_write(3'd3, 32'hCAFE_F00D);
        reg_read(3'd1, v); chk("R6 read addr 1", v, 32'h0);
        reg_read(3'd3, v); chk("R6 read addr 3", v, 32'h0);
        reg_read(3'd4, v); chk("R6 scratch untouched", v, 32'h1357_9BDF);
        reg_read(3'd2, v); chk("R6 adjust untouched", v, 32'hC001_D00D);
    endtask

    task automatic t_bad_count();
        logic [31:0] v;
        en_high();
        send_bits({28'd0, 1'b1, 32'hAAAA_5555, 3'd6}, 36);
        en_low();
        pulse(1'b1);
        wait_cyc(2 * H);
        chk("R7 ready after long frame", {31'd0, ser_ready}, 32'd1);
        en_high();
        send_bits({30'd0, 31'h2AAA_5555, 3'd6}, 34);
        en_low();
        pulse(1'b1);
        wait_cyc(2 * H);
        reg_read(3'd6, v); chk("R7 scratch 6 after bad frames", v, 32'hFFFF_0000);
        reg_read(3'd7, v);
        chk("R7 dout holds last bit", {31'd0, ser_dout}, 32'd1);
        en_high();
        chk("R11 dout cleared at frame start", {31'd0, ser_dout}, 32'd0);
        send_bits({62'd0, 2'b11}, 2);
        en_low();
        pulse(1'b0);
        for (int i = 0; i < 4; i++) pulse(1'b1);
        chk("R7 no readout on short read", {31'd0, ser_dout}, 32'd0);
        chk("R7 ready after short read", {31'd0, ser_ready}, 32'd1);
    endtask

    task automatic t_bad_dir();
        logic [31:0] v;
        en_high();
        send_bits({29'd0, 32'h0BAD_0BAD, 3'd4}, 35);
        en_low();
        pulse(1'b0);
        wait_cyc(2 * H);
        chk("R8 ready after write with dir 0", {31'd0, ser_ready}, 32'd1);
        reg_read(3'd4, v); chk("R8 scratch 4 unchanged", v, 32'h1357_9BDF);
        en_high();
        send_bits({61'd0, 3'd7}, 3);
        en_low();
        pulse(1'b1);
        wait_cyc(2 * H);
        chk("R8 ready after read with dir 1", {31'd0, ser_ready}, 32'd1);
        for (int i = 0; i < 3; i++) pulse(1'b0);
        chk("R8 dout silent", {31'd0, ser_dout}, 32'd0);
    endtask

    task automatic t_ready();
        logic [31:0] got;
        en_high();
        chk("R9 ready low after enable", {31'd0, ser_ready}, 32'd0);
        send_bits({29'd0, 32'h5A5A_0001, 3'd2}, 35);
        en_low();
        chk("R9 ready low before dir bit", {31'd0, ser_ready}, 32'd0);
        pulse(1'b1);
        wait_cyc(2 * H);
        chk("R9 ready high after commit", {31'd0, ser_ready}, 32'd1);
        got = '0;
        en_high();
        send_bits({61'd0, 3'd2}, 3);
        en_low();
        pulse(1'b0);
        for (int i = 0; i < 32; i++) begin
            pulse(1'b0);
            got = {got[30:0], ser_dout};
            if (i == 30) chk("R9 ready low during readout", {31'd0, ser_ready}, 32'd0);
        end
        wait_cyc(H);
        chk("R9 ready high after readout", {31'd0, ser_ready}, 32'd1);
        chk("R3 readout value", got, 32'h5A5A_0001);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_storage();
        t_counter();
        t_undef();
        t_bad_count();
        t_bad_dir();
        t_ready();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule